// File: doc/BRIEF.md
# Nonvolatile Wiper Position Controller

This block is the digital control core of a 100-step digitally trimmed potentiometer. A host drives three slow control lines: an active-low select, an increment strobe and a direction level. While the block is selected, every falling edge of the strobe moves a tap position counter up or down by one step. The counter stops at the two end taps and never wraps. The position leaves the block twice: as a binary number and as a one-hot tap-select vector that would steer the switch array.

A retained register stands in for the nonvolatile cell. Releasing the select line with the strobe high writes the current position into it. This starts a store period of configurable length, during which the control lines are ignored. Releasing the select line with the strobe low leaves the retained copy untouched. In both cases the block then sits in standby until the select line falls again. The soft reset does not clear the retained register. A separate recall pulse copies the retained value back into the position counter, as happens after power is applied. A separate blank-cell reset puts the retained register at a parameterised factory value.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: After the soft reset `rst_n`, `wiper_pos` is 0, `standby` is 1 and `busy` is 0.
- R2: While selected (state not standby and not storing, `cs_n` low), each falling edge of `inc_n` adds one to `wiper_pos` when `up` is 1 and subtracts one when `up` is 0. The new position appears on the third rising clock edge after the input edge: two synchroniser stages, then the edge stage.
- R3: A step up at position TAPS-1 (99) and a step down at position 0 leave `wiper_pos` unchanged.
- R4: While `cs_n` is high (standby), edges on `inc_n` do not change `wiper_pos`.
- R5: `tap_sel` has exactly one bit set at all times, and bit i is set when `wiper_pos` equals i.
- R6: A rising edge of `cs_n` while selected and with `inc_n` high copies `wiper_pos` into the retained register. It then holds `busy` at 1 for STORE_CYCLES clock cycles and afterwards enters standby.
- R7: A rising edge of `cs_n` while selected and with `inc_n` low enters standby without a store. `busy` stays 0, the new position stays on `wiper_pos`, and the retained register keeps its old value.
- R8: A one-cycle pulse on `recall` loads `wiper_pos` from the retained register on the next clock edge. The retained register survives `rst_n`. `nv_blank_n` low sets it to NV_INIT (default 50).
- R9: During a store, a low `cs_n` and edges on `inc_n` are ignored. When the store ends the block goes to standby and needs a fresh falling edge of `cs_n` to be selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Soft reset, asynchronous assert, active low; keeps the retained register |
| nv_blank_n | input | 1 | Blank-cell reset of the retained register to NV_INIT, active low |
| recall | input | 1 | Synchronous pulse: load position from retained register |
| cs_n | input | 1 | Asynchronous select line, active low |
| inc_n | input | 1 | Asynchronous increment strobe, steps on its falling edge |
| up | input | 1 | Asynchronous direction: 1 counts up, 0 counts down |
| wiper_pos | output | POS_W (7) | Binary tap position, 0 to TAPS-1 |
| tap_sel | output | TAPS (100) | One-hot tap select, bit i = tap i |
| busy | output | 1 | Store in progress |
| standby | output | 1 | Deselected / low-power state |

## Verification
The counter is driven with short runs of up and down strobes, which show the step direction and size. Long runs against each end tap separate saturation from wrap-around. Two kinds of select release, with the strobe high and with it low, are each followed by a recall. This shows whether a write to the retained copy really happened or was really skipped. Strobes sent while deselected, during a store, and after a store with the select line still low show which states accept steps. Soft reset and blank-cell reset followed by recall separate the retained register from the working counter.

// File: rtl/wnv_pkg.sv
package wnv_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_STORING = 2'd2
  } wnv_state_e;

endpackage

// File: rtl/wnv_sync.sv
// Two-stage synchroniser, one chain per bit, with per-bit reset value.
module wnv_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q;
    logic s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[b];
        s2_q <= RST_VAL[b];
      end else begin
        s1_q <= d[b];
        s2_q <= s1_q;
      end
    end
    assign q[b] = s2_q;
  end

endmodule

// File: rtl/wnv_ctrl_fsm.sv
// Edge stage, select/store state machine, store timer and retained register.
module wnv_ctrl_fsm
  import wnv_pkg::*;
#(
  parameter int POS_W        = 7,
  parameter int STORE_CYCLES = 1000000,
  parameter int NV_INIT      = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_blank_n,
  input  logic             cs_s,
  input  logic             inc_s,
  input  logic             up_s,
  input  logic [POS_W-1:0] pos,
  output logic             step_up,
  output logic             step_dn,
  output logic             busy,
  output logic             standby,
  output logic [POS_W-1:0] nv_pos
);

  localparam int TMR_W = $clog2(STORE_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(STORE_CYCLES - 1);

  logic             cs_d_q, inc_d_q;
  wnv_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             nv_en;
  logic [POS_W-1:0] nv_q;

  logic cs_fall, cs_rise, inc_fall, step;

  assign cs_fall  = cs_d_q & ~cs_s;
  assign cs_rise  = ~cs_d_q & cs_s;
  assign inc_fall = inc_d_q & ~inc_s;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    tmr_en  = 1'b0;
    nv_en   = 1'b0;
    unique case (state_q)
      ST_STANDBY: begin
        if (cs_fall) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (cs_rise) begin
          if (inc_s) begin
            state_d = ST_STORING;
            tmr_en  = 1'b1;
            tmr_d   = TMR_LOAD;
            nv_en   = 1'b1;
          end else begin
            state_d = ST_STANDBY;
          end
        end
      end
      ST_STORING: begin
        tmr_en = 1'b1;
        if (tmr_q == '0) state_d = ST_STANDBY;
        else             tmr_d   = tmr_q - 1'b1;
      end
      default: state_d = ST_STANDBY;
    endcase
  end

  assign step    = (state_q == ST_ACTIVE) & inc_fall & ~cs_s;
  assign step_up = step & up_s;
  assign step_dn = step & ~up_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q  <= 1'b1;
      inc_d_q <= 1'b1;
      state_q <= ST_STANDBY;
    end else begin
      cs_d_q  <= cs_s;
      inc_d_q <= inc_s;
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  always_ff @(posedge clk or negedge nv_blank_n) begin
    if (!nv_blank_n) nv_q <= POS_W'(NV_INIT);
    else if (nv_en)  nv_q <= pos;
  end

  assign busy    = (state_q == ST_STORING);
  assign standby = (state_q == ST_STANDBY);
  assign nv_pos  = nv_q;

endmodule

// File: rtl/wnv_pos_ctr.sv
// Saturating up/down tap position counter with recall load.
module wnv_pos_ctr #(
  parameter int TAPS  = 100,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall,
  input  logic [POS_W-1:0] nv_pos,
  input  logic             step_up,
  input  logic             step_dn,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] TOP = POS_W'(TAPS - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  assign pos_en = recall | step_up | step_dn;

  always_comb begin
    pos_d = pos_q;
    if (recall)                          pos_d = nv_pos;
    else if (step_up && (pos_q != TOP))  pos_d = pos_q + 1'b1;
    else if (step_dn && (pos_q != '0))   pos_d = pos_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/wnv_tap_dec.sv
// Binary position to one-hot tap select.
module wnv_tap_dec #(
  parameter int TAPS  = 100,
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel
);

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos == POS_W'(i));
  end

endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl #(
  parameter int TAPS         = 100,
  parameter int STORE_CYCLES = 1000000,
  parameter int NV_INIT      = 50,
  localparam int POS_W       = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nv_blank_n,
  input  logic             recall,
  input  logic             cs_n,
  input  logic             inc_n,
  input  logic             up,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel,
  output logic             busy,
  output logic             standby
);

  logic [2:0]       raw_in, sync_out;
  logic             cs_s, inc_s, up_s;
  logic             step_up, step_dn;
  logic [POS_W-1:0] nv_pos;

  assign raw_in = {cs_n, inc_n, up};
  assign {cs_s, inc_s, up_s} = sync_out;

  wnv_sync #(
    .W      (3),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  wnv_ctrl_fsm #(
    .POS_W       (POS_W),
    .STORE_CYCLES(STORE_CYCLES),
    .NV_INIT     (NV_INIT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_blank_n(nv_blank_n),
    .cs_s      (cs_s),
    .inc_s     (inc_s),
    .up_s      (up_s),
    .pos       (wiper_pos),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .busy      (busy),
    .standby   (standby),
    .nv_pos    (nv_pos)
  );

  wnv_pos_ctr #(
    .TAPS (TAPS),
    .POS_W(POS_W)
  ) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .recall (recall),
    .nv_pos (nv_pos),
    .step_up(step_up),
    .step_dn(step_dn),
    .pos    (wiper_pos)
  );

  wnv_tap_dec #(
    .TAPS (TAPS),
    .POS_W(POS_W)
  ) u_dec (
    .pos    (wiper_pos),
    .tap_sel(tap_sel)
  );

endmodule

// File: rtl/wnv_checker.sv
module wnv_checker #(
  parameter int TAPS  = 100,
  parameter int POS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             recall,
  input logic [POS_W-1:0] wiper_pos,
  input logic [TAPS-1:0]  tap_sel,
  input logic             busy,
  input logic             standby
);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !recall |=> ((wiper_pos == $past(wiper_pos)) ||
                 ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1) ||
                 ({1'b0, $past(wiper_pos)} == {1'b0, wiper_pos} + 1'b1)));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wiper_pos) < TAPS);

  a_r4_standby_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !recall) |=> $stable(wiper_pos));

  a_r5_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

  a_r6_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && standby));

  a_r9_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !recall) |=> $stable(wiper_pos));

  a_r9_store_ends_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> standby);

  a_r9_no_direct_store: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !busy);

endmodule

bind wiper_nv_ctrl wnv_checker #(
  .TAPS (TAPS),
  .POS_W(POS_W)
) u_wnv_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .recall   (recall),
  .wiper_pos(wiper_pos),
  .tap_sel  (tap_sel),
  .busy     (busy),
  .standby  (standby)
);

// File: tb/wiper_nv_ctrl_bench.sv
module wiper_nv_ctrl_bench;

  localparam int TAPS   = 100;
  localparam int STORE  = 40;
  localparam int NVINIT = 50;
  localparam int POS_W  = $clog2(TAPS);

  logic             clk, rst_n, nv_blank_n, recall, cs_n, inc_n, up;
  logic [POS_W-1:0] wiper_pos;
  logic [TAPS-1:0]  tap_sel;
  logic             busy, standby;

  typedef struct {
    string req;
    int    pos;
    bit    bsy;
    bit    stb;
  } exp_t;

  exp_t sb[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  int   m_pos  = 0;
  bit   done   = 0;

  wiper_nv_ctrl #(
    .TAPS        (TAPS),
    .STORE_CYCLES(STORE),
    .NV_INIT     (NVINIT)
  ) u_wiper_nv_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_blank_n(nv_blank_n),
    .recall    (recall),
    .cs_n      (cs_n),
    .inc_n     (inc_n),
    .up        (up),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel),
    .busy      (busy),
    .standby   (standby)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_now(string req, int pos, bit bsy, bit stb);
    exp_t e;
    e.req = req; e.pos = pos; e.bsy = bsy; e.stb = stb;
    sb.push_back(e);
    tick(1);
  endtask

  task automatic pulse_inc();
    inc_n = 1'b0; tick(4);
    inc_n = 1'b1; tick(4);
  endtask

  // Selected-state steps; model saturates at both ends.
  task automatic move(bit dir, int n);
    up = dir; tick(1);
    for (int k = 0; k < n; k++) begin
      pulse_inc();
      if (dir && m_pos < TAPS - 1) m_pos++;
      else if (!dir && m_pos > 0)  m_pos--;
    end
  endtask

  task automatic do_recall();
    recall = 1'b1; tick(1);
    recall = 1'b0; tick(1);
  endtask

  // Monitor: compare popped expectations shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t e;
        logic [TAPS-1:0] exp_tap;
        e = sb.pop_front();
        exp_tap = {{(TAPS-1){1'b0}}, 1'b1} << e.pos;
        n_vec++;
        if (int'(wiper_pos) != e.pos || busy !== e.bsy || standby !== e.stb) begin
          n_fail++;
          $display("FAIL %s: pos/busy/standby actual %0d/%0b/%0b expected %0d/%0b/%0b",
                   e.req, wiper_pos, busy, standby, e.pos, e.bsy, e.stb);
        end
        if (tap_sel !== exp_tap) begin
          n_fail++;
          $display("FAIL R5: tap_sel actual %h expected %h", tap_sel, exp_tap);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run unfinished, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nv_blank_n = 1'b0; recall = 1'b0;
    cs_n = 1'b1; inc_n = 1'b1; up = 1'b0;
    tick(3);
    rst_n = 1'b1; nv_blank_n = 1'b1;
    tick(2);
    expect_now("R1", 0, 0, 1);

    // R8: recall of blank-cell value
    do_recall(); m_pos = NVINIT;
    expect_now("R8", m_pos, 0, 1);

    // R2: select, then move both ways
    cs_n = 1'b0; tick(4);
    expect_now("R2", m_pos, 0, 0);
    move(1'b1, 3);
    expect_now("R2", m_pos, 0, 0);   // 53
    move(1'b0, 5);
    expect_now("R2", m_pos, 0, 0);   // 48

    // R6: store with inc high
    cs_n = 1'b1; tick(4);
    expect_now("R6", m_pos, 1, 0);
    // R9: selection and strobes ignored during store
    cs_n = 1'b0; pulse_inc();
    expect_now("R9", m_pos, 1, 0);
    tick(STORE);
    expect_now("R6", m_pos, 0, 1);
    // R9: still low select after store does not reselect
    pulse_inc();
    expect_now("R9", m_pos, 0, 1);
    cs_n = 1'b1; tick(4);

    // R4: strobes while deselected
    up = 1'b1; pulse_inc(); up = 1'b0; pulse_inc();
    expect_now("R4", m_pos, 0, 1);

    // R3: saturation at both ends
    cs_n = 1'b0; tick(4);
    move(1'b1, 60);
    expect_now("R3", m_pos, 0, 0);   // 99
    move(1'b0, 120);
    expect_now("R3", m_pos, 0, 0);   // 0

    // R7: release with inc low, no store
    move(1'b1, 6);
    inc_n = 1'b0; tick(4); m_pos++;
    cs_n = 1'b1; tick(4);
    expect_now("R7", m_pos, 0, 1);   // 7
    inc_n = 1'b1; tick(4);
    do_recall(); m_pos = 48;
    expect_now("R7", m_pos, 0, 1);

    // R8: retained value survives soft reset
    cs_n = 1'b0; tick(4);
    move(1'b1, 1);                   // 49
    cs_n = 1'b1; tick(4);
    expect_now("R6", m_pos, 1, 0);
    tick(STORE);
    expect_now("R6", m_pos, 0, 1);
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
    expect_now("R1", 0, 0, 1);
    do_recall(); m_pos = 49;
    expect_now("R8", m_pos, 0, 1);

    // R8: blank-cell reset restores NV_INIT
    nv_blank_n = 1'b0; tick(2); nv_blank_n = 1'b1; tick(2);
    do_recall(); m_pos = NVINIT;
    expect_now("R8", m_pos, 0, 1);

    tick(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule